// File: doc/BRIEF.md
# Byte-Partitioned SIMD Integer Multiplier

This block multiplies two 64-bit operands that are cut at run time into independent lanes. A lane always starts on a byte boundary and spans 1, 2, 4 or 8 bytes, and lanes of different sizes may share one operand word. Each byte carries a 2-bit operation code. Every byte of a lane carries the same code. The code selects the low half of the lane product, or the high half with signed×signed, signed×unsigned (a signed) or unsigned×unsigned operands.

The block produces two outputs. The first is the full double-width product of every lane, packed into a 128-bit word. The second is a 64-bit word that holds, in each lane's own bit range, the half of that product that the operation code selects. Inside the block, byte-by-byte partial products are summed only for byte pairs of the same lane. Signed operands are handled by adding a per-lane correction through carry-isolated adders. A configurable number of register levels follows the arithmetic.

Top module: `pmul_lanes`

## Requirements
- R1: For a lane of w bits starting at bit s, `prod_full[2s+2w-1:2s]` holds the 2w-bit product of the lane's operand slices. Operand a is signed unless the code is 3. Operand b is signed when the code is 0 or 1. A signed slice is sign-extended from its bit w-1.
- R2: With code 0 (low), `result[s+w-1:s]` holds the low w bits of the lane product.
- R3: With code 1 (signed high), `result[s+w-1:s]` holds bits 2w-1:w of the signed×signed lane product.
- R4: With code 2 (mixed high), `result[s+w-1:s]` holds bits 2w-1:w of the product of signed a and unsigned b.
- R5: With code 3 (unsigned high), `result[s+w-1:s]` holds bits 2w-1:w of the unsigned lane product.
- R6: Lanes are fully independent. No carry, sign or partial product crosses a boundary, including when every operand bit is set. `split[k-1]=1` starts a new lane at byte k. The op code of byte k sits at `byte_op[2k+1:2k]`.
- R7: Both outputs reflect inputs applied LEVELS clock edges earlier. Before those edges they keep their previous value.
- R8: A clock edge with `rst_n` low clears every pipeline register, so both outputs read zero.
- R9: Take a=0x0123456789ABCDEF and b=0xFEDCBA9876543210. From the LSB, the lanes are an 8-bit signed high lane, an 8-bit unsigned high lane, a 16-bit low lane and a 32-bit mixed high lane. This gives `result`=0x0121FA00FE1C28FE and `prod_full`=0x0121FA0023E20B28C94DFE1C280AFEF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a | input | 64 | Multiplicand word |
| opnd_b | input | 64 | Multiplier word |
| split | input | 7 | Bit k-1 set: a new lane begins at byte k |
| byte_op | input | 16 | Two-bit op code per byte (0 low, 1 signed high, 2 signed×unsigned high, 3 unsigned high) |
| prod_full | output | 128 | Full product of each lane at twice its bit offset |
| result | output | 64 | Selected half of each lane product at the lane offset |

## Verification
The signed correction for a negative multiplicand and the one for a negative multiplier can land in the same lane in the same cycle. Both must then be added without rippling into the neighbouring lane. The bench provokes this by sweeping all 128 boundary patterns with operands whose lane sign bits are set. One such operand is all ones, and another holds the most negative value in every lane. Every lane's full product and selected half are compared against a product the bench forms with wide signed arithmetic.

// File: rtl/pmul_pkg.sv
// Package: shared op-code type and byte granularity for the partitioned multiplier.
package pmul_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_LO    = 2'd0,
        OP_HI_SS = 2'd1,
        OP_HI_SU = 2'd2,
        OP_HI_UU = 2'd3
    } pmul_op_e;
endpackage

// File: rtl/pmul_lane_map.sv
// pmul_lane_map: turns the boundary enables into per-byte lane descriptors:
// lane-start flag, index of the lane's first byte and index one past its last.
// Assumes byte 0 always starts a lane.
module pmul_lane_map #(
    parameter int NBYTE = 8,
    localparam int IW   = $clog2(NBYTE) + 1
) (
    input  logic [NBYTE-2:0]          split,
    output logic [NBYTE-1:0]          is_start,
    output logic [NBYTE-1:0][IW-1:0]  first_idx,
    output logic [NBYTE-1:0][IW-1:0]  end_idx
);
    // Lane starts, forward scan for first byte, backward scan for lane end.
    always_comb begin
        is_start[0]  = 1'b1;
        for (int k = 1; k < NBYTE; k++) is_start[k] = split[k-1];
        first_idx[0] = '0;
        for (int k = 1; k < NBYTE; k++)
            first_idx[k] = is_start[k] ? IW'(k) : first_idx[k-1];
        end_idx[NBYTE-1] = IW'(NBYTE);
        for (int k = NBYTE - 2; k >= 0; k--)
            end_idx[k] = is_start[k+1] ? IW'(k + 1) : end_idx[k+1];
    end
endmodule

// File: rtl/pmul_part_adder.sv
// pmul_part_adder: byte-chained adder whose carry into byte k is dropped
// when kill[k] is set, so each partition wraps on its own.
module pmul_part_adder #(
    parameter int NB = 16,
    localparam int W = NB * pmul_pkg::BYTE_W
) (
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  y,
    input  logic [NB-1:0] kill,
    output logic [W-1:0]  sum
);
    localparam int BW = pmul_pkg::BYTE_W;
    logic          cy;
    logic [BW:0]   t;

    // Ripple one byte at a time, gating the carry at partition edges.
    always_comb begin
        cy  = 1'b0;
        t   = '0;
        sum = '0;
        for (int k = 0; k < NB; k++) begin
            t = {1'b0, x[k*BW +: BW]} + {1'b0, y[k*BW +: BW]}
              + {{BW{1'b0}}, cy & ~kill[k]};
            sum[k*BW +: BW] = t[BW-1:0];
            cy = t[BW];
        end
    end
endmodule

// File: rtl/pmul_pp_sum.sv
// pmul_pp_sum: sums the unsigned byte-by-byte partial products of byte pairs
// lying in the same lane. Each lane's sum fits its own 2w-bit field, so no
// lane carries into another.
module pmul_pp_sum #(
    parameter int NBYTE = 8,
    localparam int IW   = $clog2(NBYTE) + 1,
    localparam int DW   = NBYTE * pmul_pkg::BYTE_W
) (
    input  logic [DW-1:0]            a,
    input  logic [DW-1:0]            b,
    input  logic [NBYTE-1:0][IW-1:0] first_idx,
    output logic [2*DW-1:0]          usum
);
    localparam int BW = pmul_pkg::BYTE_W;
    logic [2*BW-1:0] pp;

    // Accumulate masked partial products at their byte-pair weight.
    always_comb begin
        usum = '0;
        pp   = '0;
        for (int i = 0; i < NBYTE; i++)
            for (int j = 0; j < NBYTE; j++)
                if (first_idx[i] == first_idx[j]) begin
                    pp   = (2*BW)'(a[i*BW +: BW]) * (2*BW)'(b[j*BW +: BW]);
                    usum = usum + ((2*DW)'(pp) << (BW * (i + j)));
                end
    end
endmodule

// File: rtl/pmul_lanes.sv
// pmul_lanes: top of the byte-partitioned SIMD multiplier. Unsigned lane
// products come from pmul_pp_sum. Signed lanes get -(b<<w) and/or -(a<<w)
// added through carry-isolated adders. The selected half is then picked per
// byte, and LEVELS register stages follow. Assumes all bytes of a lane share
// one op code.
module pmul_lanes #(
    parameter int NBYTE  = 8,
    parameter int LEVELS = 1,
    localparam int DW    = NBYTE * pmul_pkg::BYTE_W,
    localparam int IW    = $clog2(NBYTE) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     opnd_a,
    input  logic [DW-1:0]     opnd_b,
    input  logic [NBYTE-2:0]  split,
    input  logic [2*NBYTE-1:0] byte_op,
    output logic [2*DW-1:0]   prod_full,
    output logic [DW-1:0]     result
);
    import pmul_pkg::*;
    localparam int BW = BYTE_W;

    logic [NBYTE-1:0]          is_start;
    logic [NBYTE-1:0][IW-1:0]  first_idx, end_idx;
    logic [DW-1:0]             inc_vec, neg_a, neg_b;
    logic [NBYTE-1:0]          a_neg, b_neg;
    logic [2*DW-1:0]           usum, corr_a, corr_b, sum1, full_c;
    logic [2*NBYTE-1:0]        kill_w;
    logic [DW-1:0]             res_c;

    pmul_lane_map #(.NBYTE(NBYTE)) u_map (
        .split(split), .is_start(is_start),
        .first_idx(first_idx), .end_idx(end_idx)
    );

    pmul_pp_sum #(.NBYTE(NBYTE)) u_pp (
        .a(opnd_a), .b(opnd_b), .first_idx(first_idx), .usum(usum)
    );

    // Per-lane two's complement of each operand: ~x plus one at each lane LSB.
    always_comb begin
        inc_vec = '0;
        for (int k = 0; k < NBYTE; k++) inc_vec[k*BW] = is_start[k];
    end

    pmul_part_adder #(.NB(NBYTE)) u_neg_a (
        .x(~opnd_a), .y(inc_vec), .kill(is_start), .sum(neg_a)
    );
    pmul_part_adder #(.NB(NBYTE)) u_neg_b (
        .x(~opnd_b), .y(inc_vec), .kill(is_start), .sum(neg_b)
    );

    // Signedness per byte from its op code, sign taken from the lane top bit.
    always_comb begin
        for (int k = 0; k < NBYTE; k++) begin
            pmul_op_e op;
            op       = pmul_op_e'(byte_op[2*k +: 2]);
            a_neg[k] = (op != OP_HI_UU) & opnd_a[BW*int'(end_idx[k]) - 1];
            b_neg[k] = ((op == OP_LO) | (op == OP_HI_SS))
                     & opnd_b[BW*int'(end_idx[k]) - 1];
        end
    end

    // Place -b (for negative a) and -a (for negative b) in each lane's upper half.
    always_comb begin
        corr_a = '0;
        corr_b = '0;
        for (int k = 0; k < NBYTE; k++) begin
            if (a_neg[k]) corr_a[BW*(k + int'(end_idx[k])) +: BW] = neg_b[k*BW +: BW];
            if (b_neg[k]) corr_b[BW*(k + int'(end_idx[k])) +: BW] = neg_a[k*BW +: BW];
        end
    end

    // Product-domain partitions sit at twice the operand lane boundaries.
    for (genvar p = 0; p < 2*NBYTE; p++) begin : g_kill
        if (p % 2 == 0) begin : g_even
            assign kill_w[p] = is_start[p/2];
        end else begin : g_odd
            assign kill_w[p] = 1'b0;
        end
    end

    pmul_part_adder #(.NB(2*NBYTE)) u_add_a (
        .x(usum), .y(corr_a), .kill(kill_w), .sum(sum1)
    );
    pmul_part_adder #(.NB(2*NBYTE)) u_add_b (
        .x(sum1), .y(corr_b), .kill(kill_w), .sum(full_c)
    );

    // Select the low or high half of the lane product for every result byte.
    always_comb begin
        for (int k = 0; k < NBYTE; k++) begin
            int src;
            src = (pmul_op_e'(byte_op[2*k +: 2]) == OP_LO)
                ? k + int'(first_idx[k]) : k + int'(end_idx[k]);
            res_c[k*BW +: BW] = full_c[BW*src +: BW];
        end
    end

    if (LEVELS == 0) begin : g_comb
        assign prod_full = full_c;
        assign result    = res_c;
    end else begin : g_pipe
        logic [LEVELS-1:0][2*DW-1:0] full_q;
        logic [LEVELS-1:0][DW-1:0]   res_q;

        // Output register chain, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q <= '0;
                res_q  <= '0;
            end else begin
                full_q[0] <= full_c;
                res_q[0]  <= res_c;
                for (int l = 1; l < LEVELS; l++) begin
                    full_q[l] <= full_q[l-1];
                    res_q[l]  <= res_q[l-1];
                end
            end
        end
        assign prod_full = full_q[LEVELS-1];
        assign result    = res_q[LEVELS-1];
    end
endmodule

// File: rtl/pmul_lanes_chk.sv
// pmul_lanes_chk: port-level temporal checks for pmul_lanes, attached by bind.
// The cycle-exact checks apply when the block has exactly one register level.
module pmul_lanes_chk #(
    parameter int NBYTE  = 8,
    parameter int LEVELS = 1,
    localparam int DW    = NBYTE * 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DW-1:0]      opnd_a,
    input logic [DW-1:0]      opnd_b,
    input logic [NBYTE-2:0]   split,
    input logic [2*NBYTE-1:0] byte_op,
    input logic [2*DW-1:0]    prod_full,
    input logic [DW-1:0]      result
);
    if (LEVELS > 0) begin : g_rst
        AST_RST_CLEARS: assert property (@(posedge clk)
            !rst_n |=> (prod_full == '0 && result == '0)); // R8
    end

    if (LEVELS == 1) begin : g_one
        AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(opnd_a) && $stable(opnd_b) && $stable(split) && $stable(byte_op))
            |=> $stable(result) && $stable(prod_full)); // R7
        AST_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
            (opnd_a == '0) |=> (prod_full == '0 && result == '0)); // R1
        AST_LOW_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (split == '0 && byte_op == '0 && opnd_b == DW'(1))
            |=> (result == $past(opnd_a))); // R2
        AST_UHIGH_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (split == '0 && byte_op == '1 && opnd_b == DW'(1))
            |=> (result == '0)); // R5
    end
endmodule

bind pmul_lanes pmul_lanes_chk #(.NBYTE(NBYTE), .LEVELS(LEVELS)) u_chk (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .split(split), .byte_op(byte_op), .prod_full(prod_full), .result(result)
);

// File: tb/pmul_lanes_bench.sv
// Bench: sweeps every boundary pattern with rotating per-lane op codes and
// corner operands, comparing each lane against wide signed arithmetic.
module pmul_lanes_bench;
    localparam int PERIOD = 10;
    localparam int LAT    = 1;
    localparam int NB     = 8;
    localparam int DW     = 64;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [DW-1:0]      opnd_a, opnd_b;
    logic [NB-2:0]      split;
    logic [2*NB-1:0]    byte_op;
    logic [2*DW-1:0]    prod_full;
    logic [DW-1:0]      result;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

    pmul_lanes #(.NBYTE(NB), .LEVELS(LAT)) u_pmul_lanes (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .split(split), .byte_op(byte_op), .prod_full(prod_full), .result(result)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [129:0] got, input logic [129:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] rnd();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed ^ (seed >> 29);
    endfunction

    function automatic int lane_end(input int k, input logic [NB-2:0] sp);
        int e = k + 1;
        while (e < NB && !sp[e-1]) e++;
        return e;
    endfunction

    // Compare every lane of both outputs with an arithmetic model.
    task automatic check_lanes(input bit ones_tag);
        int k = 0;
        while (k < NB) begin
            int e, w, op;
            logic signed [129:0] av, bv, pr;
            logic [129:0] m1, m2, pm, gf, gr, er;
            string rt;
            e  = lane_end(k, split);
            w  = 8 * (e - k);
            op = int'(byte_op[2*k +: 2]);
            m1 = (130'd1 << w) - 130'd1;
            m2 = (130'd1 << (2*w)) - 130'd1;
            av = 130'(opnd_a >> (8*k)) & m1;
            bv = 130'(opnd_b >> (8*k)) & m1;
            if (op != 3 && av[w-1]) av = av - (130'sd1 <<< w);
            if ((op == 0 || op == 1) && bv[w-1]) bv = bv - (130'sd1 <<< w);
            pr = av * bv;
            pm = pr & m2;
            er = (op == 0) ? (pm & m1) : ((pm >> w) & m1);
            gf = 130'(prod_full >> (16*k)) & m2;
            gr = 130'(result >> (8*k)) & m1;
            chk(ones_tag ? "R6 lane full product" : "R1 lane full product", gf, pm);
            case (op)
                0:       rt = "R2 low half";
                1:       rt = "R3 signed high";
                2:       rt = "R4 mixed high";
                default: rt = "R5 unsigned high";
            endcase
            chk(rt, gr, er);
            k = e;
        end
    endtask

    // Mask with the top bit of each lane set.
    function automatic logic [63:0] lane_msb(input logic [NB-2:0] sp);
        logic [63:0] v = '0;
        int k = 0;
        while (k < NB) begin
            int e = lane_end(k, sp);
            v[8*e-1] = 1'b1;
            k = e;
        end
        return v;
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        opnd_a  = 64'hFFFF_FFFF_FFFF_FFFF;
        opnd_b  = 64'h7777_7777_7777_7777;
        split   = '0;
        byte_op = '0;
        repeat (3) @(negedge clk);
        chk("R8 reset full", 130'(prod_full), 130'd0);
        chk("R8 reset result", 130'(result), 130'd0);
        rst_n = 1'b1;

        // Known mixed-lane vector, with latency observed before and after.
        opnd_a = '0; opnd_b = '0;
        repeat (LAT) @(negedge clk);
        opnd_a  = 64'h0123456789ABCDEF;
        opnd_b  = 64'hFEDCBA9876543210;
        split   = 7'b0001011;
        byte_op = 16'hAA0D;
        #1;
        chk("R7 output held before edge", 130'(result), 130'd0);
        repeat (LAT) @(negedge clk);
        chk("R9 example full", 130'(prod_full), 130'h0121FA0023E20B28C94DFE1C280AFEF0);
        chk("R9 example result", 130'(result), 130'h0121FA00FE1C28FE);
        check_lanes(1'b0);

        for (int sp = 0; sp < 128; sp++) begin
            for (int rot = 0; rot < 4; rot++) begin
                for (int pat = 0; pat < 4; pat++) begin
                    int k, ln;
                    split = 7'(sp);
                    k = 0; ln = 0;
                    while (k < NB) begin
                        int e = lane_end(k, split);
                        for (int q = k; q < e; q++) byte_op[2*q +: 2] = 2'((ln + rot) % 4);
                        ln++;
                        k = e;
                    end
                    case (pat)
                        0: begin opnd_a = rnd(); opnd_b = rnd(); end
                        1: begin opnd_a = lane_msb(split) | rnd(); opnd_b = rnd(); end
                        2: begin opnd_a = '1; opnd_b = '1; end
                        default: begin opnd_a = lane_msb(split); opnd_b = lane_msb(split); end
                    endcase
                    repeat (LAT) @(negedge clk);
                    check_lanes(pat == 2);
                end
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule